// File: doc/BRIEF.md
# Row-Buffer Miss Statistics Store

This block sits in the controller of a hybrid memory, where a small DRAM serves as a cache in front of a large phase-change array. It watches the stream of accesses that the controller reports. For every recently touched phase-change row it keeps a small count of how often that row missed in the array's row buffer. Rows that keep missing have poor row locality and gain the most from sitting in DRAM. When a row's count reaches the current promotion threshold, the block raises a one-cycle request carrying that row address. It then forgets the row so that the same row is not requested twice.

The tracking table is set-associative, with 128 sets of 16 ways by default. The low row-address bits pick the set, and the remaining bits form the tag. Each way holds a valid flag, a tag, a 4-bit saturating count and a recency rank. A programmable cycle interval divides time into epochs. At the end of each epoch the whole table is wiped in one cycle, so only rows with recent reuse can qualify. At the same moment the threshold moves one step: it goes down when DRAM hits in the epoch outnumbered a programmable multiple of the promotions issued, and otherwise it goes up.

Top module: `row_miss_stats`

## Requirements
- R1: An access flagged as served by DRAM (`acc_in_dram`=1) leaves the table unchanged. It produces neither a count report nor a promotion in the following cycle.
- R2: A tracked access to a row already present adds one to its count when `acc_rb_miss`=1 and leaves it unchanged when `acc_rb_miss`=0. The count after the update appears on `rep_count` with `rep_valid`=1 one cycle after the access.
- R3: A tracked row-buffer miss to an absent row allocates a way with count 1. A tracked row-buffer hit to an absent row allocates nothing and reports count 0.
- R4: When the updated count is at least the threshold, `mig_valid` pulses for one cycle together with the report, with `mig_row` equal to the access row. The entry is invalidated, so a later miss to that row starts again at 1.
- R5: The set is `acc_row` modulo the set count, and the tag is the rest of the row. Up to WAYS rows with equal low bits are held at once without disturbing each other.
- R6: When a set is full, allocation prefers an invalid way and otherwise replaces the way least recently allocated or touched by a tracked access.
- R7: Every `cfg_interval` cycles after reset, all entries are invalidated and their counts cleared in a single cycle.
- R8: The threshold starts at THR_INIT after reset and changes only at an epoch end. It falls by one when the epoch's DRAM-hit count exceeds `cfg_mult` times its promotion count, and otherwise rises by one. Events in the epoch-end cycle itself are not counted.
- R9: The threshold never goes below 1 or above 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | An access report is present this cycle |
| acc_row | input | ROW_W | Row address of the access |
| acc_in_dram | input | 1 | 1: access was served by the DRAM cache |
| acc_rb_miss | input | 1 | 1: access missed the phase-change row buffer |
| cfg_interval | input | IVL_W | Epoch length in cycles (0 acts as 1) |
| cfg_mult | input | MULT_W | Benefit multiple for threshold adaptation |
| mig_valid | output | 1 | One-cycle promotion request |
| mig_row | output | ROW_W | Row to promote into DRAM |
| rep_valid | output | 1 | Count report for the previous tracked access |
| rep_count | output | 4 | Row miss count after the update |
| thr_level | output | 4 | Current promotion threshold |

## Verification
The properties assume that `acc_row` and the flags are known whenever `acc_valid` is high, and that `cfg_interval` and `cfg_mult` change only while reset is held. Each scenario starts from a fresh reset with its own configuration. No scenario lets a tracked access fall on an epoch-end cycle where the result would be ambiguous. The table tests use an epoch far longer than the run, and the epoch tests count cycles from the reset release so that every check lands between two epoch ends.

// File: rtl/rms_pkg.sv
package rms_pkg;
    localparam int CNT_W   = 4;
    localparam int THR_MIN = 1;
    localparam int THR_MAX = (1 << CNT_W) - 1;

    typedef logic [CNT_W-1:0] cnt_t;

    function automatic cnt_t sat_inc(cnt_t c, logic en);
        if (en && (c != cnt_t'(THR_MAX))) return cnt_t'(c + 1'b1);
        return c;
    endfunction
endpackage

// File: rtl/rms_set_lookup.sv
module rms_set_lookup #(
    parameter int WAYS  = 16,
    parameter int TAG_W = 13,
    parameter int WAY_W = 4
) (
    input  logic [WAYS-1:0]             vld_i,
    input  logic [WAYS-1:0][TAG_W-1:0]  tag_i,
    input  logic [WAYS-1:0][WAY_W-1:0]  age_i,
    input  logic [TAG_W-1:0]            tag_q,
    output logic                        hit_o,
    output logic [WAY_W-1:0]            hit_way_o,
    output logic [WAY_W-1:0]            victim_o
);
    logic [WAYS-1:0] match;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign match[w] = vld_i[w] && (tag_i[w] == tag_q);
    end

    always_comb begin
        logic free_found;
        hit_o      = |match;
        hit_way_o  = '0;
        victim_o   = '0;
        free_found = 1'b0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match[w]) hit_way_o = WAY_W'(w);
        end
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (age_i[w] == WAY_W'(WAYS - 1)) victim_o = WAY_W'(w);
        end
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!vld_i[w]) begin
                victim_o   = WAY_W'(w);
                free_found = 1'b1;
            end
        end
        if (free_found && hit_o) victim_o = hit_way_o;
    end
endmodule

// File: rtl/rms_epoch_ctrl.sv
module rms_epoch_ctrl
    import rms_pkg::*;
#(
    parameter int IVL_W    = 24,
    parameter int EVT_W    = 16,
    parameter int MULT_W   = 4,
    parameter int THR_INIT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IVL_W-1:0]  cfg_interval,
    input  logic [MULT_W-1:0] cfg_mult,
    input  logic              mig_evt,
    input  logic              hit_evt,
    output logic              expire_o,
    output cnt_t              thr_o
);
    localparam int PROD_W = EVT_W + MULT_W;

    typedef struct packed {
        logic [IVL_W-1:0] tick;
        logic [EVT_W-1:0] mig_n;
        logic [EVT_W-1:0] hit_n;
        cnt_t             thr;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic [PROD_W-1:0] cost;
    logic              benefit;

    always_comb begin
        cost     = PROD_W'(cfg_mult) * PROD_W'(ctl_q.mig_n);
        benefit  = PROD_W'(ctl_q.hit_n) > cost;
        expire_o = ({1'b0, ctl_q.tick} + {{IVL_W{1'b0}}, 1'b1}) >= {1'b0, cfg_interval};
        ctl_d    = ctl_q;
        if (expire_o) begin
            ctl_d.tick  = '0;
            ctl_d.mig_n = '0;
            ctl_d.hit_n = '0;
            if (benefit && (ctl_q.thr > cnt_t'(THR_MIN)))
                ctl_d.thr = cnt_t'(ctl_q.thr - 1'b1);
            else if (!benefit && (ctl_q.thr < cnt_t'(THR_MAX)))
                ctl_d.thr = cnt_t'(ctl_q.thr + 1'b1);
        end else begin
            ctl_d.tick = ctl_q.tick + 1'b1;
            if (mig_evt && (ctl_q.mig_n != '1)) ctl_d.mig_n = ctl_q.mig_n + 1'b1;
            if (hit_evt && (ctl_q.hit_n != '1)) ctl_d.hit_n = ctl_q.hit_n + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{tick: '0, mig_n: '0, hit_n: '0, thr: cnt_t'(THR_INIT)};
        else        ctl_q <= ctl_d;
    end

    assign thr_o = ctl_q.thr;

    AST_THR_BOUNDS: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_o >= cnt_t'(THR_MIN)) && (thr_o <= cnt_t'(THR_MAX))); // R9
    AST_THR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !expire_o |=> $stable(thr_o)); // R8
endmodule

// File: rtl/row_miss_stats.sv
module row_miss_stats
    import rms_pkg::*;
#(
    parameter int ROW_W    = 20,
    parameter int SETS     = 128,
    parameter int WAYS     = 16,
    parameter int IVL_W    = 24,
    parameter int EVT_W    = 16,
    parameter int MULT_W   = 4,
    parameter int THR_INIT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic [ROW_W-1:0]  acc_row,
    input  logic              acc_in_dram,
    input  logic              acc_rb_miss,
    input  logic [IVL_W-1:0]  cfg_interval,
    input  logic [MULT_W-1:0] cfg_mult,
    output logic              mig_valid,
    output logic [ROW_W-1:0]  mig_row,
    output logic              rep_valid,
    output logic [CNT_W-1:0]  rep_count,
    output logic [CNT_W-1:0]  thr_level
);
    localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1;
    localparam int TAG_W = ROW_W - SET_W;
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

    typedef struct packed {
        logic             mig_vld;
        logic [ROW_W-1:0] mig_row;
        logic             rep_vld;
        cnt_t             rep_cnt;
    } out_t;

    typedef struct packed {
        logic                       we;
        logic [WAYS-1:0]            vld;
        logic [WAYS-1:0][TAG_W-1:0] tag;
        cnt_t [WAYS-1:0]            cnt;
        logic [WAYS-1:0][WAY_W-1:0] age;
    } wr_t;

    logic [WAYS-1:0]            vld_q [SETS];
    logic [WAYS-1:0][TAG_W-1:0] tag_q [SETS];
    cnt_t [WAYS-1:0]            cnt_q [SETS];
    logic [WAYS-1:0][WAY_W-1:0] age_q [SETS];

    out_t out_d, out_q;
    wr_t  wr_d;

    logic [SET_W-1:0] set_idx;
    logic [TAG_W-1:0] acc_tag;
    logic             lk_hit;
    logic [WAY_W-1:0] lk_way, lk_victim;
    logic             expire, promote, pcm_acc;
    cnt_t             thr;

    assign set_idx = acc_row[SET_W-1:0];
    assign acc_tag = acc_row[ROW_W-1:SET_W];
    assign pcm_acc = acc_valid && !acc_in_dram;

    rms_set_lookup #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_lookup (
        .vld_i     (vld_q[set_idx]),
        .tag_i     (tag_q[set_idx]),
        .age_i     (age_q[set_idx]),
        .tag_q     (acc_tag),
        .hit_o     (lk_hit),
        .hit_way_o (lk_way),
        .victim_o  (lk_victim)
    );

    rms_epoch_ctrl #(.IVL_W(IVL_W), .EVT_W(EVT_W), .MULT_W(MULT_W), .THR_INIT(THR_INIT)) u_epoch (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_interval (cfg_interval),
        .cfg_mult     (cfg_mult),
        .mig_evt      (promote),
        .hit_evt      (acc_valid && acc_in_dram),
        .expire_o     (expire),
        .thr_o        (thr)
    );

    always_comb begin
        logic [WAY_W-1:0] tway;
        cnt_t             newc;
        logic             touch;
        tway    = lk_hit ? lk_way : lk_victim;
        newc    = '0;
        touch   = 1'b0;
        promote = 1'b0;
        out_d   = '0;
        wr_d    = '{we: 1'b0, vld: vld_q[set_idx], tag: tag_q[set_idx],
                    cnt: cnt_q[set_idx], age: age_q[set_idx]};
        if (pcm_acc) begin
            if (lk_hit) begin
                newc  = sat_inc(cnt_q[set_idx][lk_way], acc_rb_miss);
                touch = 1'b1;
            end else if (acc_rb_miss) begin
                newc  = cnt_t'(1);
                touch = 1'b1;
            end
            if (touch) begin
                promote           = newc >= thr;
                wr_d.we           = 1'b1;
                wr_d.cnt[tway]    = newc;
                wr_d.vld[tway]    = !promote;
                wr_d.tag[tway]    = acc_tag;
                for (int w = 0; w < WAYS; w++) begin
                    if (w == int'(tway))
                        wr_d.age[w] = '0;
                    else if (age_q[set_idx][w] < age_q[set_idx][tway])
                        wr_d.age[w] = WAY_W'(age_q[set_idx][w] + 1'b1);
                end
            end
            out_d.rep_vld = 1'b1;
            out_d.rep_cnt = newc;
            out_d.mig_vld = promote;
            out_d.mig_row = promote ? acc_row : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
            for (int s = 0; s < SETS; s++) begin
                vld_q[s] <= '0;
                tag_q[s] <= '0;
                cnt_q[s] <= '0;
                for (int w = 0; w < WAYS; w++) age_q[s][w] <= WAY_W'(w);
            end
        end else begin
            out_q <= out_d;
            if (expire) begin
                for (int s = 0; s < SETS; s++) begin
                    vld_q[s] <= '0;
                    cnt_q[s] <= '0;
                end
            end else if (wr_d.we) begin
                vld_q[set_idx] <= wr_d.vld;
                tag_q[set_idx] <= wr_d.tag;
                cnt_q[set_idx] <= wr_d.cnt;
                age_q[set_idx] <= wr_d.age;
            end
        end
    end

    assign mig_valid = out_q.mig_vld;
    assign mig_row   = out_q.mig_row;
    assign rep_valid = out_q.rep_vld;
    assign rep_count = out_q.rep_cnt;
    assign thr_level = thr;

    AST_DRAM_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_in_dram) |=> (!mig_valid && !rep_valid)); // R1
    AST_RBHIT_NO_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
        (pcm_acc && !acc_rb_miss && !lk_hit) |=> (rep_count == '0 && !mig_valid)); // R3
    AST_MIG_AT_THR: assert property (@(posedge clk) disable iff (!rst_n)
        mig_valid |-> (rep_valid && (rep_count >= $past(thr)))); // R4
    AST_EPOCH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (vld_q[0] == '0)); // R7
endmodule

// File: tb/row_miss_stats_tb.sv
module row_miss_stats_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic [11:0] acc_row = '0;
    logic        acc_in_dram = 1'b0;
    logic        acc_rb_miss = 1'b0;
    logic [23:0] cfg_interval = 24'hFFFFFF;
    logic [3:0]  cfg_mult = 4'd1;
    logic        mig_valid, rep_valid;
    logic [11:0] mig_row;
    logic [3:0]  rep_count, thr_level;

    int n_checks = 0;
    int n_fail   = 0;
    logic        s_rv, s_mv;
    logic [3:0]  s_rc;
    logic [11:0] s_mr;

    always #5 clk = ~clk;

    row_miss_stats #(.ROW_W(12), .SETS(4), .WAYS(4), .IVL_W(24), .THR_INIT(4)) u_dut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_row(acc_row),
        .acc_in_dram(acc_in_dram), .acc_rb_miss(acc_rb_miss),
        .cfg_interval(cfg_interval), .cfg_mult(cfg_mult),
        .mig_valid(mig_valid), .mig_row(mig_row), .rep_valid(rep_valid),
        .rep_count(rep_count), .thr_level(thr_level)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [23:0] ivl, input logic [3:0] mult);
        @(negedge clk);
        acc_valid = 1'b0;
        rst_n = 1'b0;
        cfg_interval = ivl;
        cfg_mult = mult;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic acc(input logic [11:0] row, input logic dram, input logic miss);
        acc_valid = 1'b1; acc_row = row; acc_in_dram = dram; acc_rb_miss = miss;
        @(negedge clk);
        s_rv = rep_valid; s_rc = rep_count; s_mv = mig_valid; s_mr = mig_row;
        acc_valid = 1'b0;
    endtask

    task automatic t_reset;
        do_reset(24'hFFFFFF, 4'd1);
        chk("R8 reset thr", thr_level, 4);
        chk("R4 reset mig_valid", mig_valid, 0);
        chk("R2 reset rep_valid", rep_valid, 0);
    endtask

    task automatic t_count;
        do_reset(24'hFFFFFF, 4'd1);
        acc(12'h015, 0, 1); chk("R3 alloc count", s_rc, 1); chk("R2 rep_valid", s_rv, 1);
        acc(12'h015, 0, 0); chk("R2 rb hit holds", s_rc, 1);
        acc(12'h015, 0, 1); chk("R2 miss incr", s_rc, 2);
        acc(12'h015, 0, 1); chk("R2 miss incr", s_rc, 3); chk("R4 below thr no mig", s_mv, 0);
    endtask

    task automatic t_rbhit_noalloc;
        do_reset(24'hFFFFFF, 4'd1);
        acc(12'h020, 0, 0); chk("R3 rb hit absent count", s_rc, 0); chk("R3 rb hit absent mig", s_mv, 0);
        acc(12'h020, 0, 1); chk("R3 no prior alloc", s_rc, 1);
    endtask

    task automatic t_dram;
        do_reset(24'hFFFFFF, 4'd1);
        acc(12'h031, 0, 1); chk("R1 setup", s_rc, 1);
        for (int i = 0; i < 3; i++) begin
            acc(12'h031, 1, 1);
            chk("R1 dram no report", s_rv, 0);
            chk("R1 dram no mig", s_mv, 0);
        end
        acc(12'h031, 0, 1); chk("R1 count untouched", s_rc, 2);
    endtask

    task automatic t_migrate;
        do_reset(24'hFFFFFF, 4'd1);
        for (int i = 0; i < 3; i++) acc(12'h042, 0, 1);
        chk("R4 pre-threshold", s_mv, 0);
        acc(12'h042, 0, 1);
        chk("R4 mig_valid", s_mv, 1); chk("R4 mig_row", s_mr, 12'h042); chk("R4 count at thr", s_rc, 4);
        acc(12'h042, 0, 1);
        chk("R4 entry invalidated", s_rc, 1); chk("R4 no repeat", s_mv, 0);
    endtask

    task automatic t_sets;
        do_reset(24'hFFFFFF, 4'd1);
        for (int i = 0; i < 4; i++) acc(12'(4 * i + 1), 0, 1);
        acc(12'h002, 0, 1);
        for (int i = 0; i < 4; i++) begin
            acc(12'(4 * i + 1), 0, 1);
            chk("R5 same set coexist", s_rc, 2);
        end
        acc(12'h002, 0, 1); chk("R5 other set", s_rc, 2);
    endtask

    task automatic t_lru;
        do_reset(24'hFFFFFF, 4'd1);
        acc(12'h003, 0, 1); acc(12'h007, 0, 1); acc(12'h00B, 0, 1); acc(12'h00F, 0, 1);
        acc(12'h003, 0, 0); chk("R6 touch", s_rc, 1);
        acc(12'h013, 0, 1); chk("R6 new alloc", s_rc, 1);
        acc(12'h003, 0, 1); chk("R6 recent kept", s_rc, 2);
        acc(12'h007, 0, 1); chk("R6 lru evicted", s_rc, 1);
        acc(12'h00F, 0, 1); chk("R6 survivor kept", s_rc, 2);
        acc(12'h00B, 0, 1); chk("R6 second lru evicted", s_rc, 1);
    endtask

    task automatic t_thr_up;
        do_reset(24'd8, 4'd1);
        repeat (12) @(negedge clk);
        chk("R8 no benefit raises", thr_level, 5);
    endtask

    task automatic t_thr_down;
        do_reset(24'd8, 4'd1);
        for (int i = 0; i < 3; i++) acc(12'h100, 1, 0);
        repeat (9) @(negedge clk);
        chk("R8 benefit lowers", thr_level, 3);
    endtask

    task automatic t_thr_limits;
        do_reset(24'd2, 4'd1);
        repeat (40) @(negedge clk);
        chk("R9 upper bound", thr_level, 15);
        do_reset(24'd4, 4'd0);
        for (int i = 0; i < 40; i++) acc(12'h200, 1, 0);
        chk("R9 lower bound", thr_level, 1);
    endtask

    task automatic t_epoch;
        do_reset(24'd50, 4'd1);
        acc(12'h055, 0, 1); chk("R7 first", s_rc, 1);
        acc(12'h055, 0, 1); chk("R7 accumulate", s_rc, 2);
        repeat (60) @(negedge clk);
        acc(12'h055, 0, 1); chk("R7 cleared at epoch", s_rc, 1);
        chk("R8 one epoch step", thr_level, 5);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_count();
        t_rbhit_noalloc();
        t_dram();
        t_migrate();
        t_sets();
        t_lru();
        t_thr_up();
        t_thr_down();
        t_thr_limits();
        t_epoch();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule